// File: doc/BRIEF.md
# Four-Slot Conversion Sequencer with Continuous Scan

This block sits between a processor bus and an external successive-approximation converter core. Software writes one control byte. The byte picks single-pass or continuous operation, single-channel or grouped-channel sampling, and a 4-bit channel field. Each write starts a fresh pass of four conversions. The block issues one start request at a time to the converter and waits for the result. It files the four results into four result slots in order. Once all four slots hold data from the current pass, it raises a completion flag.

In single-pass mode the block goes idle after the fourth result and stays idle until the next control write. In continuous mode it keeps converting. The fifth result overwrites slot 1, the sixth overwrites slot 2, and so on around the ring. The completion flag stays set after the first pass. A control write during a conversion abandons that conversion and starts the new pass at once. Any late result from the abandoned conversion is dropped.

The bus reads the control byte at address 0 and result slots 1 to 4 at addresses 1 to 4. Reads are combinational on the address.

Top module: `convSequencer`

## Requirements
- R1: After reset, address 0 reads 0x00, all four result slots read 0x00, and no start request is issued.
- R2: Within a pass, conversion k (k = 0..3) lands in result slot k+1, readable at bus address k+1.
- R3: With continuous mode off (control bit 5 = 0), exactly four start requests follow a control write. The completion flag is then set and no further start is issued until the next control write.
- R4: With continuous mode on (bit 5 = 1), conversions never stop. The flag is 0 until the fourth result of the first pass is stored and stays 1 afterwards. Result 4+j overwrites slot (j mod 4)+1.
- R5: A write to address 0 clears the completion flag. It puts a start request on the converter port in the cycle right after the write cycle, with slot index 0.
- R6: A control write during a conversion abandons it. The done pulse of the abandoned conversion updates no result slot, and the new pass fills slots 1 to 4 with its own four results.
- R7: The control byte at address 0 reads bit 7 = completion flag, bit 6 = 0, bit 5 = continuous mode, bit 4 = grouped-channel mode and bits 3:0 = channel field. Written values of bits 7 and 6 are ignored.
- R8: With bit 4 = 0, all four conversions of a pass request the channel given by bits 3:0.
- R9: With bit 4 = 1, conversion k requests channel {bits 3:2, k[1:0]}, and the written bits 1:0 do not affect the channel.
- R10: A start request lasts one cycle. The next start of a pass is issued in the cycle after the done pulse of the previous one, so with a converter latency of L cycles successive starts are L+1 cycles apart.
- R11: Bus writes to addresses other than 0 change no result slot, do not change the control byte and start no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Bus write strobe, one cycle per write |
| busAddr | input | 3 | Bus address: 0 control byte, 1 to 4 result slots |
| busWrData | input | 8 | Bus write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| cnvStart | output | 1 | One-cycle start request to the converter |
| cnvChan | output | 4 | Channel number valid with cnvStart |
| cnvDone | input | 1 | One-cycle done pulse from the converter |
| cnvResult | input | 8 | Result valid with cnvDone |

## Verification
The assertions assume that the converter answers every start request with exactly one done pulse. They also assume that answers come back in the order of the requests, and that no done pulse appears without an outstanding request. The bench drives the converter port from a behavioural stub that meets these assumptions. The stub is a fixed-latency shift pipeline, so answers stay in order even when an abort leaves an old conversion in flight. It also tags every result with a running request count, which makes a stale or misfiled result show up in the slot readback. Bus writes are held for exactly one cycle and are launched on the falling edge, away from the capture edge.

// File: rtl/convSeqPkg.sv
package convSeqPkg;

  localparam int SEQ_DATA_W  = 8;
  localparam int SEQ_CHAN_W  = 4;
  localparam int SEQ_SLOTS   = 4;
  localparam int SEQ_IDX_W   = $clog2(SEQ_SLOTS);
  localparam int SEQ_ADDR_W  = 3;
  localparam int SEQ_STALE_W = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_WAIT  = 2'd2
  } seqState_t;

  // control byte bits 5:0 in their bus positions
  typedef struct packed {
    logic                  scan;
    logic                  multi;
    logic [SEQ_CHAN_W-1:0] chan;
  } seqCfg_t;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic                 cfgWr;
    logic                 resWr;
    logic [SEQ_IDX_W-1:0] resIdx;
    logic                 setFlag;
  } seqStrobe_t;

endpackage

// File: rtl/convSeqCtrl.sv
module convSeqCtrl
  import convSeqPkg::*;
#(
  parameter int CHAN_W  = SEQ_CHAN_W,
  parameter int SLOTS   = SEQ_SLOTS,
  parameter int ADDR_W  = SEQ_ADDR_W,
  parameter int STALE_W = SEQ_STALE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  seqCfg_t           cfg,
  input  logic              cnvDone,
  output seqStrobe_t        strobe,
  output logic              cnvStart,
  output logic [CHAN_W-1:0] cnvChan
);

  localparam int IDX_W = $clog2(SLOTS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);
  localparam logic [STALE_W-1:0] STALE_ONE = STALE_W'(1);

  seqState_t          stateQ, stateD;
  logic [IDX_W-1:0]   idxQ, idxD;
  logic [STALE_W-1:0] staleQ, staleD;

  logic cfgWr;
  logic inFlight;
  logic doneStale;
  logic doneCur;
  logic lastSlot;

  assign cfgWr     = busWrEn && (busAddr == '0);
  assign inFlight  = (stateQ != SEQ_IDLE);
  assign doneStale = cnvDone && (staleQ != '0);
  assign doneCur   = cnvDone && (staleQ == '0) && (stateQ == SEQ_WAIT);
  assign lastSlot  = (idxQ == LAST_IDX);

  // next-state logic: a control write wins over everything else
  always_comb begin
    stateD = stateQ;
    idxD   = idxQ;
    staleD = doneStale ? (staleQ - STALE_ONE) : staleQ;
    if (cfgWr) begin
      stateD = SEQ_START;
      idxD   = '0;
      if (inFlight && !doneCur) begin
        staleD = staleD + STALE_ONE;
      end
    end else if (doneCur) begin
      idxD   = idxQ + 1'b1;
      stateD = (lastSlot && !cfg.scan) ? SEQ_IDLE : SEQ_START;
    end else if (stateQ == SEQ_START) begin
      stateD = SEQ_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
      idxQ   <= '0;
      staleQ <= '0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
      staleQ <= staleD;
    end
  end

  // grouped mode replaces the low channel bits with the slot index
  generate
    if (CHAN_W > IDX_W) begin : gChanGroup
      assign cnvChan = cfg.multi ? {cfg.chan[CHAN_W-1:IDX_W], idxQ} : cfg.chan;
    end else begin : gChanFlat
      assign cnvChan = cfg.multi ? CHAN_W'(idxQ) : cfg.chan;
    end
  endgenerate

  assign cnvStart = (stateQ == SEQ_START);

  always_comb begin
    strobe.cfgWr   = cfgWr;
    strobe.resWr   = doneCur && !cfgWr;
    strobe.resIdx  = idxQ;
    strobe.setFlag = doneCur && !cfgWr && lastSlot;
  end

  // R10: the start request never lasts two cycles
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cnvStart |=> !cnvStart);

  // R6: a done pulse owned by an abandoned conversion writes nothing
  a_r6_stale_discard: assert property (@(posedge clk) disable iff (!rstN)
    (cnvDone && staleQ != '0) |-> !strobe.resWr);

  // R3: nothing is filed while the sequencer is idle
  a_r3_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SEQ_IDLE) |-> !strobe.resWr);

  // R2: each filed result moves the ring to the next slot
  a_r2_slot_advance: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resWr |=> (idxQ == IDX_W'($past(idxQ) + 1'b1)));

endmodule

// File: rtl/convSeqData.sv
module convSeqData
  import convSeqPkg::*;
#(
  parameter int DATA_W = SEQ_DATA_W,
  parameter int SLOTS  = SEQ_SLOTS,
  parameter int ADDR_W = SEQ_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] cnvResult,
  output seqCfg_t           cfg,
  output logic              flag,
  output logic [DATA_W-1:0] busRdData
);

  localparam int CFG_W = $bits(seqCfg_t);

  seqCfg_t           cfgQ;
  logic              flagQ;
  logic [DATA_W-1:0] slotQ [SLOTS];
  logic              unusedWrBits;

  // bits 7 and 6 of a control write have no storage
  assign unusedWrBits = ^busWrData[DATA_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ  <= '0;
      flagQ <= 1'b0;
    end else begin
      if (strobe.cfgWr) begin
        cfgQ  <= seqCfg_t'(busWrData[CFG_W-1:0]);
        flagQ <= 1'b0;
      end else if (strobe.setFlag) begin
        flagQ <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SLOTS; s++) begin
        slotQ[s] <= '0;
      end
    end else if (strobe.resWr) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (strobe.resIdx == s[$bits(strobe.resIdx)-1:0]) begin
          slotQ[s] <= cnvResult;
        end
      end
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == '0) begin
      busRdData = {flagQ, 1'b0, cfgQ};
    end
    for (int s = 0; s < SLOTS; s++) begin
      if (busAddr == ADDR_W'(s + 1)) begin
        busRdData = slotQ[s];
      end
    end
  end

  assign cfg  = cfgQ;
  assign flag = flagQ;

  // R4: in continuous mode the flag, once set, stays set until a write
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && cfgQ.scan && !strobe.cfgWr) |=> flagQ);

  // R11: a slot only changes when it is the target of a result write
  generate
    for (genvar g = 0; g < SLOTS; g++) begin : gSlotChk
      a_r11_slot_hold: assert property (@(posedge clk) disable iff (!rstN)
        !(strobe.resWr && strobe.resIdx == g[$bits(strobe.resIdx)-1:0])
          |=> $stable(slotQ[g]));
    end
  endgenerate

endmodule

// File: rtl/convSequencer.sv
module convSequencer
  import convSeqPkg::*;
#(
  parameter int DATA_W  = SEQ_DATA_W,
  parameter int CHAN_W  = SEQ_CHAN_W,
  parameter int SLOTS   = SEQ_SLOTS,
  parameter int ADDR_W  = SEQ_ADDR_W,
  parameter int STALE_W = SEQ_STALE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              cnvStart,
  output logic [CHAN_W-1:0] cnvChan,
  input  logic              cnvDone,
  input  logic [DATA_W-1:0] cnvResult
);

  seqStrobe_t strobe;
  seqCfg_t    cfg;
  logic       flag;

  convSeqCtrl #(
    .CHAN_W (CHAN_W),
    .SLOTS  (SLOTS),
    .ADDR_W (ADDR_W),
    .STALE_W(STALE_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .cfg     (cfg),
    .cnvDone (cnvDone),
    .strobe  (strobe),
    .cnvStart(cnvStart),
    .cnvChan (cnvChan)
  );

  convSeqData #(
    .DATA_W(DATA_W),
    .SLOTS (SLOTS),
    .ADDR_W(ADDR_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .cnvResult(cnvResult),
    .cfg      (cfg),
    .flag     (flag),
    .busRdData(busRdData)
  );

  // R3: a finished single pass issues no further start
  a_r3_single_halts: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !cfg.scan && !strobe.cfgWr) |-> !cnvStart);

  // R5: a control write clears the flag and requests a conversion next cycle
  a_r5_write_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == '0) |=> (!flag && cnvStart));

endmodule

// File: tb/tb_convSequencer.sv
`timescale 1ns/100ps
module tb_convSequencer;

  localparam int LAT = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       cnvStart;
  logic [3:0] cnvChan;
  logic       cnvDone;
  logic [7:0] cnvResult;

  always #2.5 clk = ~clk;

  convSequencer dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .cnvStart(cnvStart),
    .cnvChan(cnvChan), .cnvDone(cnvDone), .cnvResult(cnvResult)
  );

  // converter stub: fixed latency, results tagged with the request count
  logic [LAT-1:0] pipeV;
  logic [7:0]     pipeD [LAT];
  logic [3:0]     startLog [256];
  logic [7:0]     resLog [256];
  int             startCyc [256];
  int             startN = 0;
  int             cyc = 0;

  assign cnvDone   = pipeV[LAT-1];
  assign cnvResult = pipeD[LAT-1];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      pipeV <= '0;
      for (int i = 0; i < LAT; i++) pipeD[i] <= '0;
    end else begin
      pipeV    <= {pipeV[LAT-2:0], cnvStart};
      pipeD[0] <= {startN[3:0], cnvChan};
      for (int i = 1; i < LAT; i++) pipeD[i] <= pipeD[i-1];
      if (cnvStart) begin
        startLog[startN & 255] <= cnvChan;
        resLog[startN & 255]   <= {startN[3:0], cnvChan};
        startCyc[startN & 255] <= cyc;
        startN <= startN + 1;
      end
    end
  end

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] addr, input logic [7:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = '0;
  endtask

  task automatic readReg(input logic [2:0] addr, output logic [7:0] val);
    busAddr = addr;
    #1;
    val = busRdData;
  endtask

  task automatic waitFlag(input int maxCyc);
    logic [7:0] v;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      readReg(3'd0, v);
      if (v[7]) break;
    end
  endtask

  // {written byte, expected readback, channel of conversions 0..3}
  localparam logic [31:0] VEC [5] = '{
    32'h0585_5555,   // single channel 5
    32'h1B9B_89AB,   // grouped, bits 3:2 = 10, low bits ignored
    32'h1090_0123,   // grouped, group 0
    32'h0F8F_FFFF,   // single channel 15
    32'hD797_4567    // bits 7/6 written high are ignored, grouped group 1
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int base;
    int keep;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(3'd0, v);
    check("R1", "control byte after reset", v, 8'h00);
    for (int k = 1; k <= 4; k++) begin
      readReg(3'(k), v);
      check("R1", "result slot after reset", v, 8'h00);
    end
    repeat (5) @(negedge clk);
    check("R1", "starts after reset", startN, 0);

    // table walk: single passes
    for (int n = 0; n < 5; n++) begin
      logic [7:0] wr;
      logic [7:0] rd;
      logic [3:0] ch [4];
      wr = VEC[n][31:24];
      rd = VEC[n][23:16];
      ch[0] = VEC[n][15:12]; ch[1] = VEC[n][11:8];
      ch[2] = VEC[n][7:4];   ch[3] = VEC[n][3:0];
      busWrite(3'd0, wr);
      check("R5", "start right after write", cnvStart, 1);
      readReg(3'd0, v);
      check("R5", "flag cleared by write", v[7], 0);
      base = startN;
      @(negedge clk);
      check("R10", "start lasts one cycle", cnvStart, 0);
      waitFlag(100);
      repeat (20) @(negedge clk);
      check("R3", "starts per single pass", startN - base, 4);
      for (int k = 0; k < 4; k++) begin
        check(wr[4] ? "R9" : "R8", "requested channel", startLog[base + k], ch[k]);
        readReg(3'(k + 1), v);
        check("R2", "slot contents", v, resLog[base + k]);
        if (k > 0)
          check("R10", "start spacing", startCyc[base + k] - startCyc[base + k - 1], LAT + 1);
      end
      readReg(3'd0, v);
      check("R7", "control readback", v, rd);
    end

    // continuous scan, grouped group 0
    busWrite(3'd0, 8'h30);
    base = startN;
    while (startN - base < 4) @(negedge clk);
    readReg(3'd0, v);
    check("R4", "flag before first pass ends", v[7], 0);
    while (startN - base < 7) @(negedge clk);
    readReg(3'd0, v);
    check("R4", "flag after first pass", v, 8'hB0);
    readReg(3'd1, v);
    check("R4", "slot 1 holds fifth result", v, resLog[base + 4]);
    readReg(3'd2, v);
    check("R4", "slot 2 holds sixth result", v, resLog[base + 5]);
    readReg(3'd3, v);
    check("R4", "slot 3 from first pass", v, resLog[base + 2]);
    readReg(3'd4, v);
    check("R4", "slot 4 from first pass", v, resLog[base + 3]);
    check("R9", "ring channel of fifth", startLog[base + 4], 0);
    check("R9", "ring channel of sixth", startLog[base + 5], 1);
    while (startN - base < 9) @(negedge clk);
    readReg(3'd0, v);
    check("R4", "flag stays set", v[7], 1);

    // abort mid-conversion with a single-pass write on channel 2
    repeat (2) @(negedge clk);
    busWrite(3'd0, 8'h02);
    readReg(3'd0, v);
    check("R5", "flag cleared by aborting write", v[7], 0);
    check("R6", "restart right after abort", cnvStart, 1);
    base = startN;
    waitFlag(100);
    repeat (20) @(negedge clk);
    check("R6", "starts after abort", startN - base, 4);
    for (int k = 0; k < 4; k++) begin
      readReg(3'(k + 1), v);
      check("R6", "slot after abort", v, resLog[base + k]);
    end

    // R11: writes to result addresses are ignored
    readReg(3'd2, v);
    keep = v;
    base = startN;
    busWrite(3'd2, 8'hEE);
    repeat (10) @(negedge clk);
    readReg(3'd2, v);
    check("R11", "slot after bus write", v, keep);
    check("R11", "no start from slot write", startN - base, 0);
    readReg(3'd0, v);
    check("R11", "control byte unchanged", v, 8'h82);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule